// File: doc/BRIEF.md
# Split-Write Blitter Command Queue

This block sits between a 16-bit host bus and a blitter engine. The host cannot write a 32-bit command in one bus cycle, so it writes each command as two halves. The upper half goes to a high-half port, which only latches it. The lower half goes to a low-half port, which joins it to the latched upper half and pushes the full word into an in-order queue. The blitter pulls words from the queue through a valid/ready handshake.

The producer does not look for a full flag. It reads the number of queued entries and pushes N further words only while that number is at most the depth minus N. The block also exposes the depth minus one as a read-only size value. A clear control drops every queued entry at once. A two-bit interrupt status register records blitter completion and queue overflow. Each status bit is cleared by writing a one to it, and an enable register decides which status bits drive the interrupt line.

Top module: `blit_cmd_queue`

## Requirements
- R1: After a synchronous active-low reset, `q_count` is 0, `cmd_valid` is 0, `int_stat` and `int_en` are 0, `irq` is 0, and `q_size_m1` reads DEPTH-1 (511 at the default depth).
- R2: A write to `cmd_hi_we` only latches `host_wdata` as the upper half. A write to `cmd_lo_we` pushes the word {latched upper half, `host_wdata`}, so the upper half is bits 31:16 and the write data is bits 15:0.
- R3: A low-half write that has no new high-half write before it reuses the last latched upper half. The upper half is 0 after reset.
- R4: `q_count` equals the words accepted minus the words popped, and it is visible one cycle after the push or pop. Words leave the queue in push order. A pop happens when `cmd_valid` and `cmd_ready` are both high, and `cmd_valid` is high exactly when `q_count` is non-zero.
- R5: A push while `q_count` equals DEPTH is dropped, even if a pop happens in the same cycle. The queue contents and `q_count` stay unchanged, and `int_stat` bit 1 (overflow) is set.
- R6: A write to `q_clear_we` with `host_wdata[0]`=1 empties the queue, so `q_count` is 0 the next cycle. A push or pop in the same cycle is discarded. A write with bit 0 = 0 has no effect.
- R7: A `blit_done` pulse sets `int_stat` bit 0. A write to `int_stat_we` clears each status bit whose `host_wdata` bit is 1 and leaves the other bits alone. If a bit is set and cleared in the same cycle, the set wins.
- R8: A write to `int_en_we` loads `host_wdata[1:0]` into `int_en`. `irq` is high exactly when `int_stat` and `int_en` have a common set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wdata | input | 16 | Host write data shared by all write strobes |
| cmd_hi_we | input | 1 | Latch the upper command half |
| cmd_lo_we | input | 1 | Write the lower half and push the word |
| q_clear_we | input | 1 | Clear strobe, acts when data bit 0 is 1 |
| int_en_we | input | 1 | Load the interrupt enable bits |
| int_stat_we | input | 1 | Write-one-to-clear of interrupt status |
| q_count | output | $clog2(DEPTH)+1 | Number of queued, unexecuted words |
| q_size_m1 | output | $clog2(DEPTH)+1 | Queue depth minus one |
| int_stat | output | 2 | Bit 0 completion, bit 1 overflow |
| int_en | output | 2 | Interrupt enable bits |
| irq | output | 1 | Interrupt request |
| blit_done | input | 1 | Completion pulse from the blitter |
| cmd_valid | output | 1 | A command word is available |
| cmd_data | output | 32 | Oldest queued command word |
| cmd_ready | input | 1 | Blitter accepts the word this cycle |

## Verification
The bench runs with an eight-entry queue and goes after each fill level from one entry to full, drains the queue after each level, and targets these corner cases:

- **Word order.** A design that swapped the halves, or that let a low write pick up a stale or zeroed upper half, would deliver the wrong words.
- **Full queue.** It pushes into a full queue, once alone and once with a pop in the same cycle. A design that wrapped a pointer there would overwrite the oldest word, leave the count off by one, or fail to raise overflow.
- **Clear control.** It writes the clear with bit 0 low and with bit 0 high. A design that ignored the data bit would wipe the queue on a zero write.
- **Interrupt status and enables.** It checks write-one-to-clear per bit, including a clear that collides with a completion pulse, and sweeps all enable and status combinations. A design that cleared the whole register or let the clear beat the set would lose an event.

// File: rtl/cq_pkg.sv
// Package: shared widths and status bit positions for the command queue.
// Assumes a 16-bit host bus and 32-bit blitter command words.
package cq_pkg;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int STAT_W   = 2;
    localparam int STAT_DONE = 0;   // completion bit
    localparam int STAT_OVF  = 1;   // overflow bit
endpackage

// File: rtl/cq_assembler.sv
// Module: joins two 16-bit host writes into one 32-bit command word.
// The high-half write only latches; the low-half write emits a push strobe
// with the combined word in the same cycle. Assumes the host does not
// write both halves in one cycle (if it does, the word uses the old half).
module cq_assembler
    import cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] wdata,
    input  logic              hi_we,
    input  logic              lo_we,
    output logic              push,
    output logic [WORD_W-1:0] push_word
);
    logic [HALF_W-1:0] hi_q;

    // Hold the most recent upper half until the next high-half write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (hi_we)
            hi_q <= wdata;
    end

    // Emit the completed word on a low-half write.
    always_comb begin
        push      = lo_we;
        push_word = {hi_q, wdata};
    end

    // R3: the latched half only changes on a high-half write.
    p_hold_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |=> $stable(hi_q));
    // R2: a high-half write lands in the latch.
    p_latch_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> hi_q == $past(wdata));
endmodule

// File: rtl/cq_fifo.sv
// Module: in-order word queue with an occupancy count.
// Pushes into a full queue are dropped and reported on drop.
// Clear wins over push and pop in the same cycle. DEPTH must be a power of two.
module cq_fifo #(
    parameter int DEPTH  = 512,
    parameter int WIDTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             clr,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             drop
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, push_ok, pop_ok;

    // Decode occupancy and the accepted push and pop for this cycle.
    always_comb begin
        full     = (count == CW'(DEPTH));
        rd_valid = (count != '0);
        rd_data  = mem[rd_ptr];
        pop_ok   = rd_valid && rd_ready && !clr;
        push_ok  = push && !full && !clr;
        drop     = push && full && !clr;
    end

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and the count, or reset them on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: the count never exceeds the depth.
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R4: a lone pop lowers the count by one.
    p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !clr && !push) |=> count == $past(count) - 1'b1);
    // R5: a push into a full queue leaves the count at the depth when nothing pops.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr && !rd_ready) |=> count == CW'(DEPTH));
    // R6: a clear empties the queue.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/cq_irq.sv
// Module: interrupt status with write-one-to-clear bits and an enable mask.
// A set event wins over a clear of the same bit in the same cycle.
module cq_irq
    import cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic              ovf_evt,
    input  logic              stat_we,
    input  logic              en_we,
    input  logic [STAT_W-1:0] wbits,
    output logic [STAT_W-1:0] stat,
    output logic [STAT_W-1:0] en,
    output logic              irq
);
    logic [STAT_W-1:0] set_v;

    // Collect the set events by bit position.
    always_comb begin
        set_v            = '0;
        set_v[STAT_DONE] = done_evt;
        set_v[STAT_OVF]  = ovf_evt;
    end

    // Update the status bits: clear the written ones, then apply sets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat <= '0;
        else
            stat <= (stat & ~(stat_we ? wbits : '0)) | set_v;
    end

    // Load the enable mask from the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= '0;
        else if (en_we)
            en <= wbits;
    end

    // Drive the request from enabled status bits.
    always_comb irq = |(stat & en);

    // R7: a completion pulse is recorded.
    p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> stat[STAT_DONE]);
    // R7: writing one to a bit with no event clears it.
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && wbits[STAT_DONE] && !done_evt) |=> !stat[STAT_DONE]);
    // R7: writing zero leaves the overflow bit alone.
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[STAT_OVF] && !(stat_we && wbits[STAT_OVF])) |=> stat[STAT_OVF]);
endmodule

// File: rtl/blit_cmd_queue.sv
// Module: top of the split-write blitter command queue.
// Wires the half-word assembler, the word queue and the interrupt status.
// Assumes one host write strobe per cycle and a power-of-two DEPTH.
module blit_cmd_queue
    import cq_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       host_wdata,
    input  logic              cmd_hi_we,
    input  logic              cmd_lo_we,
    input  logic              q_clear_we,
    input  logic              int_en_we,
    input  logic              int_stat_we,
    output logic [CW-1:0]     q_count,
    output logic [CW-1:0]     q_size_m1,
    output logic [1:0]        int_stat,
    output logic [1:0]        int_en,
    output logic              irq,
    input  logic              blit_done,
    output logic              cmd_valid,
    output logic [31:0]       cmd_data,
    input  logic              cmd_ready
);
    logic              push;
    logic [WORD_W-1:0] push_word;
    logic              drop;
    logic              clr;

    // Qualify the clear strobe with its data bit; publish the size value.
    always_comb begin
        clr       = q_clear_we && host_wdata[0];
        q_size_m1 = CW'(DEPTH - 1);
    end

    cq_assembler u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata     (host_wdata),
        .hi_we     (cmd_hi_we),
        .lo_we     (cmd_lo_we),
        .push      (push),
        .push_word (push_word)
    );

    cq_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_word),
        .clr       (clr),
        .rd_ready  (cmd_ready),
        .rd_valid  (cmd_valid),
        .rd_data   (cmd_data),
        .count     (q_count),
        .drop      (drop)
    );

    cq_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_evt (blit_done),
        .ovf_evt  (drop),
        .stat_we  (int_stat_we),
        .en_we    (int_en_we),
        .wbits    (host_wdata[STAT_W-1:0]),
        .stat     (int_stat),
        .en       (int_en),
        .irq      (irq)
    );

    // R5: a dropped push is recorded as overflow.
    p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> int_stat[STAT_OVF]);
    // R6: a clear written with data bit 0 low does not disturb the count.
    p_clear_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_clear_we && !host_wdata[0] && !cmd_lo_we && !cmd_ready) |=> $stable(q_count));
endmodule

// File: tb/blit_cmd_queue_test.sv
module blit_cmd_queue_test;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic clk = 0;
    logic rst_n = 0;
    logic [15:0] host_wdata = '0;
    logic cmd_hi_we = 0, cmd_lo_we = 0, q_clear_we = 0, int_en_we = 0, int_stat_we = 0;
    logic blit_done = 0, cmd_ready = 0;
    logic [CW-1:0] q_count, q_size_m1;
    logic [1:0] int_stat, int_en;
    logic irq, cmd_valid;
    logic [31:0] cmd_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] mq[$];
    logic [15:0] hi_model = '0;
    logic [1:0] st_model = '0;

    always #5 clk = ~clk;

    blit_cmd_queue #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata),
        .cmd_hi_we(cmd_hi_we), .cmd_lo_we(cmd_lo_we), .q_clear_we(q_clear_we),
        .int_en_we(int_en_we), .int_stat_we(int_stat_we),
        .q_count(q_count), .q_size_m1(q_size_m1), .int_stat(int_stat),
        .int_en(int_en), .irq(irq), .blit_done(blit_done),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_hi(input logic [15:0] v);
        host_wdata = v; cmd_hi_we = 1; tick(); cmd_hi_we = 0;
        hi_model = v;
    endtask

    task automatic write_lo(input logic [15:0] v);
        host_wdata = v; cmd_lo_we = 1; tick(); cmd_lo_we = 0;
        if (mq.size() < DEPTH) mq.push_back({hi_model, v});
        else st_model[1] = 1'b1;
    endtask

    task automatic pop_check(input string req);
        check(req, {31'd0, cmd_valid}, 32'd1);
        check(req, cmd_data, mq[0]);
        cmd_ready = 1; tick(); cmd_ready = 0;
        void'(mq.pop_front());
        check(req, 32'(q_count), 32'(mq.size()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 count", 32'(q_count), 0);
        check("R1 valid", {31'd0, cmd_valid}, 0);
        check("R1 stat", 32'(int_stat), 0);
        check("R1 en", 32'(int_en), 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 size", 32'(q_size_m1), DEPTH - 1);

        // R3: low write before any high write uses a zero upper half
        write_lo(16'h1234);
        check("R3 reset hi", cmd_data, 32'h0000_1234);
        pop_check("R3 pop");

        // R2 R4: every fill level, then drain in order
        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) begin
                write_hi(16'(n * 256 + i));
                write_lo(16'(16'hF000 ^ (n * 16 + i)));
                check("R4 count up", 32'(q_count), 32'(i + 1));
            end
            for (int i = 0; i < n; i++) pop_check("R2 R4 drain");
            check("R4 empty valid", {31'd0, cmd_valid}, 0);
        end

        // R3: repeated low writes reuse the latched half
        write_hi(16'hABCD);
        write_lo(16'h0001);
        write_lo(16'h0002);
        pop_check("R3 reuse a");
        pop_check("R3 reuse b");

        // R4: push and pop together keep the count
        write_lo(16'h0010);
        write_lo(16'h0011);
        check("R4 head", cmd_data, mq[0]);
        host_wdata = 16'h0012; cmd_lo_we = 1; cmd_ready = 1; tick();
        cmd_lo_we = 0; cmd_ready = 0;
        void'(mq.pop_front()); mq.push_back({hi_model, 16'h0012});
        check("R4 simul count", 32'(q_count), 2);
        pop_check("R4 simul order");
        pop_check("R4 simul order");

        // R5: fill, then push while full
        for (int i = 0; i < DEPTH; i++) write_lo(16'(16'h0200 + i));
        check("R5 full count", 32'(q_count), DEPTH);
        write_lo(16'hDEAD);
        check("R5 drop count", 32'(q_count), DEPTH);
        check("R5 ovf bit", 32'(int_stat), 32'(st_model));
        check("R5 head kept", cmd_data, mq[0]);
        // R5: push with pop while full is still dropped
        host_wdata = 16'hBEEF; cmd_lo_we = 1; cmd_ready = 1; tick();
        cmd_lo_we = 0; cmd_ready = 0;
        void'(mq.pop_front());
        check("R5 drop with pop", 32'(q_count), DEPTH - 1);
        check("R5 next head", cmd_data, mq[0]);

        // R6: clear with bit 0 low is ignored, then a real clear
        host_wdata = 16'hFFFE; q_clear_we = 1; tick(); q_clear_we = 0;
        check("R6 no clear", 32'(q_count), DEPTH - 1);
        check("R6 no clear head", cmd_data, mq[0]);
        host_wdata = 16'h0001; q_clear_we = 1; tick(); q_clear_we = 0;
        mq.delete();
        check("R6 cleared", 32'(q_count), 0);
        check("R6 cleared valid", {31'd0, cmd_valid}, 0);
        write_hi(16'h5A5A); write_lo(16'hA5A5);
        pop_check("R6 after clear");

        // R7: completion set, per-bit clear, set beats clear
        blit_done = 1; tick(); blit_done = 0; st_model[0] = 1;
        check("R7 done set", 32'(int_stat), 32'(st_model));
        host_wdata = 16'h0002; int_stat_we = 1; tick(); int_stat_we = 0;
        st_model[1] = 0;
        check("R7 clear ovf only", 32'(int_stat), 32'(st_model));
        host_wdata = 16'h0001; int_stat_we = 1; blit_done = 1; tick();
        int_stat_we = 0; blit_done = 0;
        check("R7 set wins", 32'(int_stat), 32'(st_model));
        host_wdata = 16'h0001; int_stat_we = 1; tick(); int_stat_we = 0;
        st_model[0] = 0;
        check("R7 clear done", 32'(int_stat), 0);

        // R8: sweep all enable and status combinations
        for (int s = 0; s < 4; s++) begin
            host_wdata = 16'h0003; int_stat_we = 1; tick(); int_stat_we = 0;
            if (s[0]) begin blit_done = 1; tick(); blit_done = 0; end
            if (s[1]) begin
                for (int i = 0; i <= DEPTH; i++) begin host_wdata = 16'(i); cmd_lo_we = 1; tick(); end
                cmd_lo_we = 0;
                host_wdata = 16'h0001; q_clear_we = 1; tick(); q_clear_we = 0;
            end
            check("R8 stat", 32'(int_stat), 32'(s));
            for (int e = 0; e < 4; e++) begin
                host_wdata = 16'(e); int_en_we = 1; tick(); int_en_we = 0;
                check("R8 en", 32'(int_en), 32'(e));
                check("R8 irq", {31'd0, irq}, {31'd0, |(2'(s) & 2'(e))});
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule